// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block gives the fetch stage a next fetch address in the same cycle as the current fetch address arrives, before anything is known about the instruction at that address. It is a table of 2^IDX_W entries. The slot for an address is picked by the address bits just above the two byte-offset bits. Each slot keeps a valid flag, the complete address of the control transfer that owns it, the predicted destination and a one-bit confidence hint. A fetch address that matches a valid slot in full is steered to the stored destination. Every other fetch address simply advances by four bytes.

The table is written only from the resolve side, once a control transfer has been executed late in the pipeline. Taken transfers allocate or refresh their slot. A transfer that resolves not-taken removes its own slot. Results of ordinary instructions never reach the storage. In the same cycle as a resolve, the block compares what the table would have predicted for that address with the real outcome, and raises a mispredict flag that the pipeline can use to discard wrongly fetched work.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, empties every slot: afterwards each lookup reports `fetch_hit`=0, `fetch_hint`=0 and `fetch_next_pc`=`fetch_pc`+4.
- R2: A lookup whose slot is empty, or whose slot holds a different full 32-bit address, reports `fetch_hit`=0 and `fetch_next_pc`=`fetch_pc`+4. This holds even when only the upper address bits differ.
- R3: A lookup whose slot is valid and holds exactly `fetch_pc` reports `fetch_hit`=1 and `fetch_next_pc` equal to the stored destination.
- R4: A resolve with `res_valid`=1, `res_is_cti`=1 and `res_taken`=1 writes {valid, `res_pc`, `res_target`} into its slot. It replaces any previous owner. Lookups see the new entry from the next cycle on.
- R5: A resolve with `res_is_cti`=0 leaves the table unchanged, whatever `res_taken` and `res_target` carry.
- R6: A not-taken control-transfer resolve whose full address owns its slot clears that slot. A not-taken resolve whose address does not own the slot leaves the slot untouched.
- R7: While `res_valid`=1, `res_mispredict` is 1 exactly when the table's current prediction for `res_pc` differs from the real next address. The prediction is the stored destination on a full match and `res_pc`+4 otherwise. The real next address is `res_target` for a taken control transfer and `res_pc`+4 otherwise. While `res_valid`=0 the flag is 0. The flag is combinational.
- R8: A lookup in the same cycle as a write to the same slot returns the contents from before the write.
- R9: A fresh allocation sets the hint to 0. A taken resolve that hits its slot with an equal destination sets the hint to 1. `fetch_hint` is 1 only on a hit whose hint is 1.
- R10: The slot number is `pc[IDX_W+1:2]`. Addresses that differ in those bits occupy separate slots. Addresses that agree in them evict one another.
- R11: While `res_valid`=0 the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| fetch_next_pc | output | PC_W | Predicted next fetch address |
| fetch_hit | output | 1 | Lookup matched a valid slot |
| fetch_hint | output | 1 | Matched slot has been confirmed taken |
| res_valid | input | 1 | A resolved instruction is presented |
| res_is_cti | input | 1 | Resolved instruction is a branch or jump |
| res_taken | input | 1 | Resolved transfer was taken |
| res_pc | input | PC_W | Address of the resolved instruction |
| res_target | input | PC_W | Real destination of the resolved transfer |
| res_mispredict | output | 1 | Table prediction for `res_pc` was wrong |

## Verification
The bench builds the block with PC_W=32 and IDX_W=3, so the table has eight slots. With a small pool of upper address bits, the random phase then keeps producing address pairs that share a slot but differ in their upper bits. This drives full-address rejection, eviction, hint confirmation and invalidation of a slot owned by another address far more often than a 128-slot table would. Same-cycle lookup and update of one slot also come up many times in the random phase.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Action the resolve side requests from the table for one slot
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_ALLOC   = 2'd1,
    UPD_CONFIRM = 2'd2,
    UPD_INVAL   = 2'd3
  } upd_act_e;

endpackage

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  // fetch read port
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PC_W-1:0]  rd_pc,
  output logic [PC_W-1:0]  rd_tgt,
  output logic             rd_hint,
  // resolve read port
  input  logic [IDX_W-1:0] rs_idx,
  output logic             rs_valid,
  output logic [PC_W-1:0]  rs_pc,
  output logic [PC_W-1:0]  rs_tgt,
  output logic             rs_hint,
  // write port
  input  upd_act_e         wr_act,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [PC_W-1:0]  wr_tgt
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hint_q;
  logic [PC_W-1:0]    pc_q  [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  // Control bits: reset and per-action update
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      hint_q  <= '0;
    end else begin
      unique case (wr_act)
        UPD_ALLOC: begin
          valid_q[wr_idx] <= 1'b1;
          hint_q[wr_idx]  <= 1'b0;
        end
        UPD_CONFIRM: hint_q[wr_idx]  <= 1'b1;
        UPD_INVAL:   valid_q[wr_idx] <= 1'b0;
        default: ;
      endcase
    end
  end

  // Payload: no reset, guarded by valid_q
  always_ff @(posedge clk) begin
    if (!rst && wr_act == UPD_ALLOC) begin
      pc_q[wr_idx]  <= wr_pc;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  // Reads see register contents, so a same-cycle write is not visible
  assign rd_valid = valid_q[rd_idx];
  assign rd_pc    = pc_q[rd_idx];
  assign rd_tgt   = tgt_q[rd_idx];
  assign rd_hint  = hint_q[rd_idx];

  assign rs_valid = valid_q[rs_idx];
  assign rs_pc    = pc_q[rs_idx];
  assign rs_tgt   = tgt_q[rs_idx];
  assign rs_hint  = hint_q[rs_idx];

  // Assertions
  logic seen_edge_q;
  always_ff @(posedge clk) seen_edge_q <= 1'b1;

  assert_reset_empties_R1: assert property (@(posedge clk)
    (seen_edge_q && $past(rst)) |-> (valid_q == '0));

  assert_inval_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_act == UPD_INVAL) |=> !valid_q[$past(wr_idx)]);

  assert_alloc_weak_hint_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_act == UPD_ALLOC) |=> (valid_q[$past(wr_idx)] && !hint_q[$past(wr_idx)]));

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            res_valid,
  input  logic            res_is_cti,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_pc,
  input  logic [PC_W-1:0] res_target,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic [PC_W-1:0] rs_tgt,
  output logic            rs_hit,
  output upd_act_e        upd_act,
  output logic            mispredict
);

  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  logic            went_taken;
  logic [PC_W-1:0] predicted_pc;
  logic [PC_W-1:0] actual_pc;

  assign rs_hit       = rs_valid && (rs_pc == res_pc);
  assign went_taken   = res_is_cti && res_taken;
  assign predicted_pc = rs_hit ? rs_tgt : seq_pc(res_pc);
  assign actual_pc    = went_taken ? res_target : seq_pc(res_pc);
  assign mispredict   = res_valid && (predicted_pc != actual_pc);

  always_comb begin
    upd_act = UPD_NONE;
    if (res_valid && res_is_cti) begin
      if (res_taken) begin
        upd_act = (rs_hit && rs_tgt == res_target) ? UPD_CONFIRM : UPD_ALLOC;
      end else if (rs_hit) begin
        upd_act = UPD_INVAL;
      end
    end
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] fetch_next_pc,
  output logic            fetch_hit,
  output logic            fetch_hint,
  input  logic            res_valid,
  input  logic            res_is_cti,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_pc,
  input  logic [PC_W-1:0] res_target,
  output logic            res_mispredict
);

  localparam int IDX_LO = 2;

  function automatic logic [IDX_W-1:0] slot_of(input logic [PC_W-1:0] pc);
    return pc[IDX_LO +: IDX_W];
  endfunction

  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  logic             rd_valid, rd_hint, rs_valid, rs_hint, rs_hit;
  logic [PC_W-1:0]  rd_pc, rd_tgt, rs_pc, rs_tgt;
  logic [IDX_W-1:0] fetch_idx, res_idx;
  upd_act_e         upd_act;

  assign fetch_idx = slot_of(fetch_pc);
  assign res_idx   = slot_of(res_pc);

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (fetch_idx),
    .rd_valid (rd_valid),
    .rd_pc    (rd_pc),
    .rd_tgt   (rd_tgt),
    .rd_hint  (rd_hint),
    .rs_idx   (res_idx),
    .rs_valid (rs_valid),
    .rs_pc    (rs_pc),
    .rs_tgt   (rs_tgt),
    .rs_hint  (rs_hint),
    .wr_act   (upd_act),
    .wr_idx   (res_idx),
    .wr_pc    (res_pc),
    .wr_tgt   (res_target)
  );

  btb_resolve #(.PC_W(PC_W)) u_resolve (
    .res_valid  (res_valid),
    .res_is_cti (res_is_cti),
    .res_taken  (res_taken),
    .res_pc     (res_pc),
    .res_target (res_target),
    .rs_valid   (rs_valid),
    .rs_pc      (rs_pc),
    .rs_tgt     (rs_tgt),
    .rs_hit     (rs_hit),
    .upd_act    (upd_act),
    .mispredict (res_mispredict)
  );

  assign fetch_hit     = rd_valid && (rd_pc == fetch_pc);
  assign fetch_next_pc = fetch_hit ? rd_tgt : seq_pc(fetch_pc);
  assign fetch_hint    = fetch_hit && rd_hint;

  // Assertions
  assert_taken_lands_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && res_valid && res_is_cti && res_taken) && res_pc == $past(res_pc))
      |-> (rs_hit && rs_tgt == $past(res_target)));

  assert_plain_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_is_cti) |-> (upd_act == UPD_NONE));

  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (upd_act == UPD_NONE));

  assert_idle_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_mispredict);

  assert_hint_needs_hit_R9: assert property (@(posedge clk) disable iff (rst)
    fetch_hint |-> fetch_hit);

  assert_confirm_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && upd_act == UPD_CONFIRM) && res_pc == $past(res_pc))
      |-> (rs_hit && rs_hint));

  logic unused_ok;
  assign unused_ok = rs_hint;

endmodule

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb;

  localparam int PC_W  = 32;
  localparam int IDX_W = 3;
  localparam int NSLOT = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst;
  logic [PC_W-1:0] fetch_pc, fetch_next_pc, res_pc, res_target;
  logic            fetch_hit, fetch_hint, res_valid, res_is_cti, res_taken, res_mispredict;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural reference: one record per slot
  bit              m_valid [NSLOT];
  bit              m_hint  [NSLOT];
  logic [PC_W-1:0] m_pc    [NSLOT];
  logic [PC_W-1:0] m_tgt   [NSLOT];

  always #5 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_next_pc(fetch_next_pc),
    .fetch_hit(fetch_hit), .fetch_hint(fetch_hint), .res_valid(res_valid),
    .res_is_cti(res_is_cti), .res_taken(res_taken), .res_pc(res_pc),
    .res_target(res_target), .res_mispredict(res_mispredict)
  );

  function automatic int slot(input logic [PC_W-1:0] pc);
    return int'((pc / 4) % NSLOT);
  endfunction

  function automatic bit owns(input logic [PC_W-1:0] pc);
    return m_valid[slot(pc)] && m_pc[slot(pc)] === pc;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive, compare against the reference, clock, update the reference
  task automatic step(input string tag, input logic [PC_W-1:0] fpc,
                      input bit rv, input bit cti, input bit tk,
                      input logic [PC_W-1:0] rpc, input logic [PC_W-1:0] rtgt);
    logic [PC_W-1:0] e_next, pred, real_next;
    bit e_hit, e_hint, e_mis;
    fetch_pc = fpc; res_valid = rv; res_is_cti = cti; res_taken = tk;
    res_pc = rpc; res_target = rtgt;
    #1;
    e_hit  = owns(fpc);
    e_next = e_hit ? m_tgt[slot(fpc)] : fpc + 32'd4;
    e_hint = e_hit && m_hint[slot(fpc)];
    pred      = owns(rpc) ? m_tgt[slot(rpc)] : rpc + 32'd4;
    real_next = (cti && tk) ? rtgt : rpc + 32'd4;
    e_mis  = rv && (pred !== real_next);
    check(tag, "fetch_hit", 32'(fetch_hit), 32'(e_hit));
    check(tag, "fetch_next_pc", fetch_next_pc, e_next);
    check(tag, "fetch_hint", 32'(fetch_hint), 32'(e_hint));
    check(tag, "res_mispredict", 32'(res_mispredict), 32'(e_mis));
    @(posedge clk);
    if (rv && cti) begin
      if (tk) begin
        if (owns(rpc) && m_tgt[slot(rpc)] === rtgt) m_hint[slot(rpc)] = 1'b1;
        else begin
          m_valid[slot(rpc)] = 1'b1; m_hint[slot(rpc)] = 1'b0;
          m_pc[slot(rpc)] = rpc;     m_tgt[slot(rpc)] = rtgt;
        end
      end else if (owns(rpc)) m_valid[slot(rpc)] = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input logic [PC_W-1:0] fpc);
    step(tag, fpc, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; fetch_pc = '0; res_valid = 1'b1; res_is_cti = 1'b1;
    res_taken = 1'b1; res_pc = 32'h100; res_target = 32'h300;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin m_valid[i] = 0; m_hint[i] = 0; end

    // R1: empty after reset, even though a taken resolve was held during reset
    idle("R1", 32'h100);
    idle("R1", 32'h104);
    // R4 + R8 + R7: allocate; same-cycle lookup sees the old (empty) slot
    step("R8", 32'h100, 1, 1, 1, 32'h100, 32'h400);
    idle("R3", 32'h100);
    // R2: same slot, other upper bits
    idle("R2", 32'h120);
    // R10: a different slot coexists
    step("R10", 32'h100, 1, 1, 1, 32'h104, 32'h800);
    idle("R10", 32'h104);
    idle("R10", 32'h100);
    // R9: confirm with equal destination, no mispredict
    step("R9", 32'h100, 1, 1, 1, 32'h100, 32'h400);
    idle("R9", 32'h100);
    // R4: new destination replaces, hint drops
    step("R4", 32'h100, 1, 1, 1, 32'h100, 32'h500);
    idle("R4", 32'h100);
    // R5: plain instruction with taken/target set changes nothing
    step("R5", 32'h108, 1, 0, 1, 32'h108, 32'h999);
    idle("R5", 32'h108);
    step("R5", 32'h100, 1, 0, 1, 32'h100, 32'h600);
    idle("R5", 32'h100);
    // R11: inputs toggling with res_valid low
    step("R11", 32'h100, 0, 1, 1, 32'h100, 32'h700);
    idle("R11", 32'h100);
    // R6: not-taken from a non-owner keeps the slot, from the owner clears it
    step("R6", 32'h100, 1, 1, 0, 32'h120, 32'h0);
    idle("R6", 32'h100);
    step("R6", 32'h100, 1, 1, 0, 32'h100, 32'h0);
    idle("R6", 32'h100);
    // R10: eviction by an alias
    step("R10", 32'h104, 1, 1, 1, 32'h124, 32'hA00);
    idle("R10", 32'h104);
    idle("R10", 32'h124);

    // Mixed random traffic, compared every cycle (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] fpc, rpc, tg;
      int r;
      fpc = ($urandom % 4) << (IDX_W + 2) | (($urandom % NSLOT) << 2);
      rpc = ($urandom % 4) << (IDX_W + 2) | (($urandom % NSLOT) << 2);
      if ($urandom % 2 == 0) rpc = fpc;
      tg  = 32'h1000 + (($urandom % 3) << 4);
      r   = int'($urandom % 8);
      step("R7", fpc, r != 0, r > 1, r > 3, rpc, tg);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule